// File: doc/BRIEF.md
# Successive-Approximation Converter Control and Register Port

This block holds the digital side of a 10-bit successive-approximation analog-to-digital converter in a small 8-bit microcontroller. Software reaches it through a byte-wide register port with three addresses: a control register holding the channel number and the done flag, and two read-only result registers. Writing the control register with its done bit cleared launches a conversion. The block selects the analog channel, holds the sample-enable output for one cycle, and then runs a binary search over the 1024 levels of an external resistor ladder. It drives the trial code on the DAC output and reads back one comparator bit per step.

When the search ends, the 10-bit code is stored, the done flag rises and a one-cycle interrupt request is raised. What the low result register returns depends on the read order. Read alone, it returns the eight most significant result bits, which suits software that only needs 8-bit precision. Read directly after the high register, it returns the bottom eight bits, so the two reads together give the full 10-bit value.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After reset, the control register at 0x34 reads 0x10 (done = 1, channel 0), both result registers read 0, and chanSel, sampleEn, irq and dacCode are all 0.
- R2: Bits 2:0 of the control register are the channel number and drive chanSel. Bit 4 reads as the done flag, where 1 means idle or finished. Bits 3, 5, 6 and 7 always read 0, and every control write updates the channel.
- R3: A control write with bit 4 = 0 in cycle c starts a conversion. sampleEn is 1 in cycle c+1 only, and the done flag reads 0 from cycle c+1. The comparison of result bit k takes place in cycle c+2+(9-k).
- R4: During the compare cycle for bit k, dacCode equals the bits already kept OR'ed with 1<<k, so it is 512 in cycle c+2. Bit k is kept when cmpIn = 1, meaning the input is at or above the DAC level. With an ideal comparator, the stored result equals the input level in steps of 1/1024 of the reference span.
- R5: A control write with bit 4 = 1 starts nothing: sampleEn stays 0, the done flag and the result are unchanged, and only the channel is updated.
- R6: A start written while a conversion runs abandons that conversion and begins a new one on the newly written channel.
- R7: A read of 0x35 that is not directly preceded by a read of 0x36 returns result bits 9:2.
- R8: A read of 0x36 returns result bits 9:8 in its bits 1:0 and 0 above them. The next read of 0x35 returns result bits 7:0 and consumes the order state, so a further 0x35 read returns bits 9:2 again.
- R9: A conversion start clears the read-order state left by an earlier 0x36 read.
- R10: The result registers change only when a conversion completes. A read during a conversion returns the previous result.
- R11: On completion, in cycle c+12, irq is 1 for exactly one cycle and the done flag reads 1.
- R12: A start write that lands in the final compare cycle wins. No irq is raised, the result is not updated, and a fresh conversion follows with the usual timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 8 | Register address |
| busWr | input | 1 | Write strobe, one cycle per write |
| busRd | input | 1 | Read strobe, one cycle per read |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, valid in the cycle busRd is high, 0 otherwise |
| chanSel | output | 3 | Analog channel select to the input multiplexer |
| dacCode | output | 10 | Trial code to the resistor ladder |
| sampleEn | output | 1 | Sample phase of the comparator |
| cmpIn | input | 1 | Comparator result, 1 when the input is at or above the ladder level |
| irq | output | 1 | One-cycle conversion-complete request |

## Verification
Two events can fall on the same clock edge: the final comparison step that stores the result and raises irq, and a software start write. The bench provokes this by counting cycles from a first start and placing a second start write exactly in the last compare cycle. It then checks that irq stays low, that sampleEn rises for the new sample, that the done flag reads 0, and that the 8-bit read still returns the older result until the second conversion delivers the new input level. An exhaustive sweep over all 1024 input levels, rotating through the five channels, judges the search arithmetically against the ideal comparator model.

// File: rtl/sar_conv_pkg.sv
package sar_conv_pkg;
  localparam int RES_W = 10;
  localparam int IDX_W = $clog2(RES_W);

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SAMPLE = 2'd1,
    ST_CMP    = 2'd2
  } convState_t;

  // strobes from the sequencer to the search datapath
  typedef struct packed {
    logic             clearAcc;
    logic             stepBit;
    logic             commit;
    logic             cmpPhase;
    logic [IDX_W-1:0] bitIdx;
  } dpStrobe_t;
endpackage

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
  import sar_conv_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int CH_W      = 3,
  parameter int DONE_BIT  = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h34,
  parameter logic [ADDR_W-1:0] LO_ADDR   = 8'h35,
  parameter logic [ADDR_W-1:0] HI_ADDR   = 8'h36
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [DATA_W-1:0] busWdata,
  output logic [CH_W-1:0]   chanSel,
  output logic              sampleEn,
  output logic              irq,
  output logic              doneFlag,
  output logic              hiReadFirst,
  output dpStrobe_t         strb
);
  localparam logic [IDX_W-1:0] MSB_IDX = IDX_W'(RES_W - 1);

  convState_t       stateQ;
  logic [IDX_W-1:0] bitIdxQ;
  logic             startReq;
  logic             ctrlWr;

  always_comb begin
    ctrlWr   = busWr && (busAddr == CTRL_ADDR);
    startReq = ctrlWr && !busWdata[DONE_BIT];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ      <= ST_IDLE;
      bitIdxQ     <= '0;
      doneFlag    <= 1'b1;
      irq         <= 1'b0;
      chanSel     <= '0;
      hiReadFirst <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (ctrlWr) chanSel <= busWdata[CH_W-1:0];
      if (startReq) begin
        stateQ   <= ST_SAMPLE;
        doneFlag <= 1'b0;
        bitIdxQ  <= MSB_IDX;
      end else begin
        case (stateQ)
          ST_SAMPLE: stateQ <= ST_CMP;
          ST_CMP: begin
            if (bitIdxQ == '0) begin
              stateQ   <= ST_IDLE;
              doneFlag <= 1'b1;
              irq      <= 1'b1;
            end else begin
              bitIdxQ <= bitIdxQ - 1'b1;
            end
          end
          default: stateQ <= ST_IDLE;
        endcase
      end
      // read-order tracking; a start has priority
      if (startReq)                          hiReadFirst <= 1'b0;
      else if (busRd && busAddr == HI_ADDR)  hiReadFirst <= 1'b1;
      else if (busRd && busAddr == LO_ADDR)  hiReadFirst <= 1'b0;
    end
  end

  always_comb begin
    sampleEn      = (stateQ == ST_SAMPLE);
    strb.clearAcc = startReq;
    strb.cmpPhase = (stateQ == ST_CMP);
    strb.stepBit  = (stateQ == ST_CMP) && !startReq;
    strb.commit   = (stateQ == ST_CMP) && !startReq && (bitIdxQ == '0);
    strb.bitIdx   = bitIdxQ;
  end

  // R11: completion request lasts one cycle
  a_r11_irq_single: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);

  // R11: request only together with a set done flag
  a_r11_irq_with_done: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> doneFlag);

  // R3: done only drops after a start write on the port
  a_r3_done_falls_on_start: assert property (@(posedge clk) disable iff (!rstN)
    $fell(doneFlag) |-> $past(busWr && busAddr == CTRL_ADDR && !busWdata[DONE_BIT]));

  // R3: sample phase lasts one cycle and hands over to the MSB trial
  a_r3_sample_to_msb: assert property (@(posedge clk) disable iff (!rstN)
    (sampleEn && !startReq) |=> (strb.cmpPhase && strb.bitIdx == MSB_IDX));
endmodule

// File: rtl/sar_conv_dp.sv
module sar_conv_dp
  import sar_conv_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int CH_W   = 3,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h34,
  parameter logic [ADDR_W-1:0] LO_ADDR   = 8'h35,
  parameter logic [ADDR_W-1:0] HI_ADDR   = 8'h36,
  parameter int DONE_BIT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic              cmpIn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic [CH_W-1:0]   chanSel,
  input  logic              doneFlag,
  input  logic              hiReadFirst,
  output logic [RES_W-1:0]  dacCode,
  output logic [DATA_W-1:0] busRdata
);
  logic [RES_W-1:0]  accQ;
  logic [RES_W-1:0]  accNext;
  logic [RES_W-1:0]  trialBit;
  logic [RES_W-1:0]  resultQ;
  logic [DATA_W-1:0] ctrlByte;
  logic [DATA_W-1:0] hiByte;
  logic [DATA_W-1:0] loByte;

  always_comb begin
    accNext              = accQ;
    accNext[strb.bitIdx] = cmpIn;
    trialBit             = strb.cmpPhase ? (RES_W'(1) << strb.bitIdx) : '0;
    dacCode              = accQ | trialBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accQ    <= '0;
      resultQ <= '0;
    end else begin
      if (strb.clearAcc)     accQ <= '0;
      else if (strb.stepBit) accQ <= accNext;
      if (strb.commit) resultQ <= accNext;
    end
  end

  always_comb begin
    ctrlByte           = '0;
    ctrlByte[CH_W-1:0] = chanSel;
    ctrlByte[DONE_BIT] = doneFlag;
    hiByte             = DATA_W'(resultQ >> DATA_W);
    loByte             = hiReadFirst ? resultQ[DATA_W-1:0]
                                     : resultQ[RES_W-1 -: DATA_W];
    busRdata = '0;
    if (busRd) begin
      if (busAddr == CTRL_ADDR)    busRdata = ctrlByte;
      else if (busAddr == HI_ADDR) busRdata = hiByte;
      else if (busAddr == LO_ADDR) busRdata = loByte;
    end
  end

  // R10: stored result moves only on a commit strobe
  a_r10_result_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> $stable(resultQ));

  // R4: the trial bit is always the only bit at or below the index in compare
  a_r4_trial_onehot: assert property (@(posedge clk) disable iff (!rstN)
    strb.cmpPhase |-> $onehot0(dacCode & ((RES_W'(2) << strb.bitIdx) - RES_W'(1))));
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
  import sar_conv_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic [7:0]   busAddr,
  input  logic         busWr,
  input  logic         busRd,
  input  logic [7:0]   busWdata,
  output logic [7:0]   busRdata,
  output logic [2:0]   chanSel,
  output logic [9:0]   dacCode,
  output logic         sampleEn,
  input  logic         cmpIn,
  output logic         irq
);
  dpStrobe_t strb;
  logic      doneFlag;
  logic      hiReadFirst;

  sar_conv_seq u_seq (
    .clk        (clk),
    .rstN       (rstN),
    .busAddr    (busAddr),
    .busWr      (busWr),
    .busRd      (busRd),
    .busWdata   (busWdata),
    .chanSel    (chanSel),
    .sampleEn   (sampleEn),
    .irq        (irq),
    .doneFlag   (doneFlag),
    .hiReadFirst(hiReadFirst),
    .strb       (strb)
  );

  sar_conv_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .cmpIn      (cmpIn),
    .busAddr    (busAddr),
    .busRd      (busRd),
    .chanSel    (chanSel),
    .doneFlag   (doneFlag),
    .hiReadFirst(hiReadFirst),
    .dacCode    (dacCode),
    .busRdata   (busRdata)
  );
endmodule

// File: tb/sim_sar_conv_ctrl.sv
module sim_sar_conv_ctrl;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] busAddr = '0;
  logic       busWr = 1'b0;
  logic       busRd = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic [2:0] chanSel;
  logic [9:0] dacCode;
  logic       sampleEn;
  logic       cmpIn;
  logic       irq;
  logic [9:0] vin [0:7];

  int nChecks = 0;
  int nErr = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  // ideal multiplexer and comparator
  assign cmpIn = (vin[chanSel] >= dacCode);

  sar_conv_ctrl u0 (.*);

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(posedge clk);
    #1 busWr = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    #1 d = busRdata;
    @(posedge clk);
    #1 busRd = 1'b0;
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nErr++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    int prev;
    for (int j = 0; j < 8; j++) vin[j] = 10'd0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk("R1 irq", irq, 0);
    chk("R1 sampleEn", sampleEn, 0);
    chk("R1 chanSel", chanSel, 0);
    chk("R1 dacCode", dacCode, 0);
    busRead(8'h34, rd); chk("R1 ctrl", rd, 8'h10);
    busRead(8'h36, rd); chk("R1 hi", rd, 0);
    busRead(8'h35, rd); chk("R1 lo", rd, 0);

    // R2/R5: write bit4=1 with junk in unused bits
    busWrite(8'h34, 8'hFF);
    @(negedge clk);
    chk("R5 no sample", sampleEn, 0);
    chk("R2 chanSel", chanSel, 7);
    busRead(8'h34, rd); chk("R2 R5 ctrl readback", rd, 8'h17);
    busRead(8'h35, rd); chk("R5 result unchanged", rd, 0);

    // exhaustive sweep: R3 R4 R7 R8 R11
    for (int v = 0; v < 1024; v++) begin
      int ch;
      bit tOk;
      ch = v % 5;
      for (int j = 0; j < 8; j++) vin[j] = 10'((v * 7 + j * 131 + 3) % 1024);
      vin[ch] = 10'(v);
      busWrite(8'h34, 8'(ch));
      @(negedge clk);
      chk("R3 sample cycle", sampleEn, 1);
      chk("R2 channel", chanSel, ch);
      @(negedge clk);
      chk("R4 msb trial", dacCode, 512);
      tOk = (sampleEn == 1'b0) && (irq == 1'b0);
      for (int k = 0; k < 9; k++) begin
        @(negedge clk);
        if (irq || sampleEn) tOk = 1'b0;
      end
      chk("R3 quiet during search", tOk, 1);
      @(negedge clk);
      chk("R11 irq at completion", irq, 1);
      busRead(8'h34, rd);
      chk("R11 done flag", rd, 8'h10 | ch);
      chk("R11 irq one cycle", irq, 0);
      if (v % 2 == 0) begin
        busRead(8'h36, rd); chk("R8 hi bits", rd, v >> 8);
        busRead(8'h35, rd); chk("R8 lo bits", rd, v & 255);
        if (v % 8 == 0) begin
          busRead(8'h35, rd); chk("R8 order consumed", rd, v >> 2);
        end
      end else begin
        busRead(8'h35, rd); chk("R7 eight-bit read", rd, v >> 2);
      end
    end
    prev = 1023;

    // R10: reads during a conversion return the old result
    vin[2] = 10'd100;
    busWrite(8'h34, 8'h02);
    busRead(8'h35, rd); chk("R10 old result mid conversion", rd, prev >> 2);
    busRead(8'h34, rd); chk("R3 done low while busy", rd, 8'h02);
    waitCycles(14);
    busRead(8'h36, rd); chk("R10 new hi", rd, 100 >> 8);
    busRead(8'h35, rd); chk("R10 new lo", rd, 100 & 255);

    // R9: start clears a pending order state
    busRead(8'h36, rd);
    vin[3] = 10'd613;
    busWrite(8'h34, 8'h03);
    waitCycles(14);
    busRead(8'h35, rd); chk("R9 order cleared by start", rd, 613 >> 2);

    // R6: restart mid conversion onto a new channel
    vin[1] = 10'd300; vin[2] = 10'd777;
    busWrite(8'h34, 8'h01);
    waitCycles(4);
    busWrite(8'h34, 8'h02);
    @(negedge clk);
    chk("R6 resample", sampleEn, 1);
    waitCycles(14);
    busRead(8'h36, rd); chk("R6 hi", rd, 777 >> 8);
    busRead(8'h35, rd); chk("R6 lo", rd, 777 & 255);

    // R12: start in the final compare cycle
    vin[4] = 10'd901;
    busWrite(8'h34, 8'h04);
    waitCycles(10);
    vin[4] = 10'd42;
    busWrite(8'h34, 8'h04);
    @(negedge clk);
    chk("R12 no irq", irq, 0);
    chk("R12 new sample", sampleEn, 1);
    busRead(8'h34, rd); chk("R12 done low", rd, 8'h04);
    busRead(8'h35, rd); chk("R12 result not updated", rd, 777 >> 2);
    waitCycles(14);
    busRead(8'h36, rd); chk("R12 second hi", rd, 0);
    busRead(8'h35, rd); chk("R12 second lo", rd, 42);

    // R5: bit4=1 write while idle keeps result and flag
    busWrite(8'h34, 8'h11);
    @(negedge clk);
    chk("R5 no start", sampleEn, 0);
    busRead(8'h34, rd); chk("R5 ctrl", rd, 8'h11);
    busRead(8'h35, rd); chk("R5 result kept", rd, 42 >> 2);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end
endmodule